// File: doc/BRIEF.md
# NAND Frame Program Sequencer

This block runs a single frame-program operation on a NAND flash device that sits behind a simple port-mapped bridge. Each access to the bridge selects a 4-bit port code, which chooses the bridge's function, and carries a data byte. The access is either a write strobe or a read strobe. On a start pulse the sequencer walks through a fixed order of bridge accesses. It turns the device on and sets up the control lines. It then sends the data-input command, the destination address and a 32-byte frame. After that it issues the program and status commands and polls until the device is ready. Finally it protects the device again, reads the final status and turns the device off.

The frame bytes come from a word buffer that the host fills. The sequencer puts out a word index, the host returns the 32-bit word combinationally, and the sequencer picks one byte lane from it. When the operation ends, a one-cycle done pulse is raised, together with a fail flag that is valid in that cycle. A program error or a poll timeout both set the fail flag.

Top module: `nand_prog_seq`

## Requirements
- R1: While and after reset with no start, `br_wr`, `br_rd`, `done` and `fail` are all 0.
- R2: A start pulse in the idle state launches one operation. A start during an operation is ignored, and without a start no access is issued.
- R3: The first four accesses are writes of data 00h, to the ports in this order: 8h (chip enable on), 3h (address latch off), 4h (spare area on), 7h (write protect off).
- R4: Next comes a write of 80h to port 1h (command), then a write of 00h to port 2h (address latch on).
- R5: Three writes to port 0h (data) follow. They carry `dest_addr[7:0]`, `dest_addr[15:8]` and `dest_addr[23:16]` in that order, which are the address bytes A7–A0, A16–A9 and A24–A17.
- R6: A write of 00h to port 3h comes next, then exactly 32 writes to port 0h. Frame byte i comes from the buffer word i[4:2] (`buf_idx`), in byte lane i[1:0]. Lane 0 is bits [7:0].
- R7: After the frame, 10h (program) and then 70h (read status) are written to port 1h.
- R8: Reads of port 0h repeat until one returns bit 6 set, which means ready.
- R9: After a ready read the sequencer writes to port 6h (write protect on), reads port 0h once and writes to port 9h (chip enable off). It then raises `done` for one cycle with `fail` equal to bit 0 of that last read.
- R10: If POLL_LIMIT polls in a row return busy, the sequencer writes to port 9h and then raises `done` with `fail` = 1.
- R11: Each strobe stays high for `hold_cyc` cycles, or for 1 cycle when `hold_cyc` is 0. Between strobes there are exactly GAP_CYC low cycles. The first strobe starts one cycle after start is sampled. Port and data stay steady while a strobe is high. `done` appears in the GAP_CYC-th low cycle after the last strobe.
- R12: `br_wr` and `br_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches one operation when idle |
| hold_cyc | input | HOLD_W | Strobe length in cycles (0 is treated as 1) |
| dest_addr | input | 24 | Three destination address bytes |
| buf_idx | output | WIDX | Word index into the frame buffer |
| buf_word | input | 32 | Buffer word at `buf_idx` |
| br_port | output | 4 | Bridge port code |
| br_wdata | output | 8 | Bridge write data |
| br_wr | output | 1 | Bridge write strobe |
| br_rd | output | 1 | Bridge read strobe |
| br_rdata | input | 8 | Bridge read data, sampled in the last strobe cycle |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Program failure or timeout, valid with `done` |

## Verification
The assertions check the cycle-level rules on every cycle. They cover strobe exclusivity, a steady port and data while a strobe is high, a low cycle after every strobe, `done` as a single pulse with the bridge quiet, and the bound on the poll counter. Only the bench scenarios can show the order of the accesses. They also show the address and frame byte values, the lane mapping, the poll count before ready or timeout, the fail value, and the strobe and gap lengths for several `hold_cyc` settings, including the case where a start during an operation has no effect.

// File: rtl/nps_pkg.sv
// Shared definitions for the NAND frame program sequencer.
// Assumes the bridge decodes the 4-bit port codes listed here.
package nps_pkg;

    typedef enum logic [4:0] {
        ST_IDLE, ST_CE_ON, ST_ALE_OFF_A, ST_SPARE_ON, ST_UNPROT,
        ST_CMD_LOAD, ST_ALE_ON, ST_ADDR0, ST_ADDR1, ST_ADDR2,
        ST_ALE_OFF_B, ST_FRAME, ST_CMD_PROG, ST_CMD_STAT, ST_POLL,
        ST_PROT, ST_FINAL, ST_CE_OFF
    } step_e;

    localparam logic [3:0] PORT_DATA    = 4'h0;
    localparam logic [3:0] PORT_CMD     = 4'h1;
    localparam logic [3:0] PORT_ALE_ON  = 4'h2;
    localparam logic [3:0] PORT_ALE_OFF = 4'h3;
    localparam logic [3:0] PORT_SPARE   = 4'h4;
    localparam logic [3:0] PORT_WP_ON   = 4'h6;
    localparam logic [3:0] PORT_WP_OFF  = 4'h7;
    localparam logic [3:0] PORT_CE_ON   = 4'h8;
    localparam logic [3:0] PORT_CE_OFF  = 4'h9;

    localparam logic [7:0] OP_LOAD = 8'h80;
    localparam logic [7:0] OP_PROG = 8'h10;
    localparam logic [7:0] OP_STAT = 8'h70;

    typedef struct packed {
        logic [3:0] port;
        logic [7:0] data;
        logic       rd;
    } access_t;

endpackage

// File: rtl/nps_strobe_timer.sv
// Access timer: runs one strobe of hold_cyc cycles (minimum 1) and then a gap.
// Assumes GAP_CYC >= 2. The idle cycle after the gap is the last gap cycle.
module nps_strobe_timer #(
    parameter int HOLD_W  = 4,
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HOLD_W-1:0] hold_cyc,
    output logic              strobe,
    output logic              strobe_last,
    output logic              slot_done
);
    localparam int GAP_W = $clog2(GAP_CYC) + 1;
    localparam int CW    = (HOLD_W > GAP_W) ? HOLD_W : GAP_W;

    typedef enum logic [1:0] {T_IDLE, T_STB, T_GAP} tphase_e;
    tphase_e       phase;
    logic [CW-1:0] cnt;

    // Phase and countdown for the current access slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= T_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                T_IDLE: if (run) begin
                    phase <= T_STB;
                    cnt   <= (hold_cyc == '0) ? '0 : CW'(hold_cyc - 1'b1);
                end
                T_STB: if (cnt == '0) begin
                    phase <= T_GAP;
                    cnt   <= CW'(GAP_CYC - 2);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (cnt == '0) phase <= T_IDLE;
                         else cnt <= cnt - 1'b1;
            endcase
        end
    end

    assign strobe      = (phase == T_STB);
    assign strobe_last = strobe && (cnt == '0);
    assign slot_done   = (phase == T_GAP) && (cnt == '0);

endmodule

// File: rtl/nps_lane_pick.sv
// Frame byte selector: word index from the upper byte-index bits,
// byte lane from the two low bits (lane 0 is the least significant byte).
module nps_lane_pick #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [31:0]      buf_word,
    output logic [IDX_W-3:0] word_idx,
    output logic [7:0]       byte_out
);
    logic [7:0] lanes [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lanes[g] = buf_word[8*g +: 8];
    end

    assign word_idx = byte_idx[IDX_W-1:2];
    assign byte_out = lanes[byte_idx[1:0]];

endmodule

// File: rtl/nps_poll_guard.sv
// Counts busy status polls. Flags expiry after POLL_LIMIT busy polls in a row.
// Assumes clear is held while the read-status command is in progress.
module nps_poll_guard #(
    parameter int POLL_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic busy_seen,
    output logic expired
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    logic [CW-1:0] cnt;

    // Saturating count of busy polls.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                 cnt <= '0;
        else if (busy_seen && !expired)      cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= CW'(POLL_LIMIT));

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(POLL_LIMIT));

endmodule

// File: rtl/nand_prog_seq.sv
// NAND frame program sequencer: issues the fixed order of bridge accesses
// that program one 32-byte frame, then reports done and fail.
// Assumes br_rdata is valid in the last strobe cycle of a read; status bit 6
// set means ready, bit 0 set means program error.
module nand_prog_seq
    import nps_pkg::*;
#(
    parameter int FRAME_BYTES = 32,
    parameter int HOLD_W      = 4,
    parameter int GAP_CYC     = 2,
    parameter int POLL_LIMIT  = 8,
    parameter int RDY_BIT     = 6,
    localparam int IDX_W      = $clog2(FRAME_BYTES),
    localparam int WIDX       = IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold_cyc,
    input  logic [23:0]       dest_addr,
    output logic [WIDX-1:0]   buf_idx,
    input  logic [31:0]       buf_word,
    output logic [3:0]        br_port,
    output logic [7:0]        br_wdata,
    output logic              br_wr,
    output logic              br_rd,
    input  logic [7:0]        br_rdata,
    output logic              done,
    output logic              fail
);
    step_e            step;
    logic [IDX_W-1:0] byte_idx;
    logic             rdy_q, fail_q, done_q;
    logic             strobe, strobe_last, slot_done, expired;
    logic [7:0]       frame_byte;
    access_t          acc;

    nps_strobe_timer #(.HOLD_W(HOLD_W), .GAP_CYC(GAP_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(step != ST_IDLE), .hold_cyc(hold_cyc),
        .strobe(strobe), .strobe_last(strobe_last), .slot_done(slot_done));

    nps_lane_pick #(.IDX_W(IDX_W)) u_lane (
        .byte_idx(byte_idx), .buf_word(buf_word),
        .word_idx(buf_idx), .byte_out(frame_byte));

    nps_poll_guard #(.POLL_LIMIT(POLL_LIMIT)) u_guard (
        .clk(clk), .rst_n(rst_n), .clear(step == ST_CMD_STAT),
        .busy_seen(strobe_last && step == ST_POLL && !br_rdata[RDY_BIT]),
        .expired(expired));

    // Port, data and direction of the access for the current step.
    always_comb begin
        acc = '{port: PORT_DATA, data: 8'h00, rd: 1'b0};
        case (step)
            ST_CE_ON:     acc.port = PORT_CE_ON;
            ST_ALE_OFF_A: acc.port = PORT_ALE_OFF;
            ST_SPARE_ON:  acc.port = PORT_SPARE;
            ST_UNPROT:    acc.port = PORT_WP_OFF;
            ST_CMD_LOAD:  begin acc.port = PORT_CMD; acc.data = OP_LOAD; end
            ST_ALE_ON:    acc.port = PORT_ALE_ON;
            ST_ADDR0:     acc.data = dest_addr[7:0];
            ST_ADDR1:     acc.data = dest_addr[15:8];
            ST_ADDR2:     acc.data = dest_addr[23:16];
            ST_ALE_OFF_B: acc.port = PORT_ALE_OFF;
            ST_FRAME:     acc.data = frame_byte;
            ST_CMD_PROG:  begin acc.port = PORT_CMD; acc.data = OP_PROG; end
            ST_CMD_STAT:  begin acc.port = PORT_CMD; acc.data = OP_STAT; end
            ST_POLL:      acc.rd = 1'b1;
            ST_PROT:      acc.port = PORT_WP_ON;
            ST_FINAL:     acc.rd = 1'b1;
            ST_CE_OFF:    acc.port = PORT_CE_OFF;
            default:      ;
        endcase
    end

    // Step sequencing, frame byte counting, status capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= ST_IDLE;
            byte_idx <= '0;
            rdy_q    <= 1'b0;
            fail_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (strobe_last && step == ST_POLL)  rdy_q  <= br_rdata[RDY_BIT];
            if (strobe_last && step == ST_FINAL) fail_q <= br_rdata[0];
            if (step == ST_IDLE) begin
                if (start) begin
                    step     <= ST_CE_ON;
                    byte_idx <= '0;
                    fail_q   <= 1'b0;
                end
            end else if (slot_done) begin
                case (step)
                    ST_FRAME:
                        if (byte_idx == IDX_W'(FRAME_BYTES - 1)) step <= ST_CMD_PROG;
                        else byte_idx <= byte_idx + 1'b1;
                    ST_POLL:
                        if (rdy_q) step <= ST_PROT;
                        else if (expired) begin
                            step   <= ST_CE_OFF;
                            fail_q <= 1'b1;
                        end
                    ST_CE_OFF: begin
                        step   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                    default: step <= step_e'(step + 5'd1);
                endcase
            end
        end
    end

    assign br_port  = acc.port;
    assign br_wdata = acc.data;
    assign br_wr    = strobe && !acc.rd;
    assign br_rd    = strobe && acc.rd;
    assign done     = done_q;
    assign fail     = fail_q;

    logic unused_status_bits;
    assign unused_status_bits = ^{br_rdata[7], br_rdata[5:1]};

    a_r12_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_wr && br_rd));
    a_r11_steady_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((br_wr || br_rd) && $past(br_wr || br_rd)) |-> ($stable(br_port) && $stable(br_wdata)));
    a_r11_low_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(br_wr || br_rd) |=> !(br_wr || br_rd));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(br_wr || br_rd));

endmodule

// File: tb/nand_prog_seq_tb.sv
module nand_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_W = 4, GAP_CYC = 2, POLL_LIMIT = 8, WIDX = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [HOLD_W-1:0] hold_cyc = '0;
    logic [23:0] dest_addr = '0;
    logic [WIDX-1:0] buf_idx;
    logic [31:0] buf_word;
    logic [3:0] br_port;
    logic [7:0] br_wdata, br_rdata;
    logic br_wr, br_rd, done, fail;

    logic [31:0] mem [8];
    int busy_n = 0, rd_seen = 0;
    logic fail_bit = 1'b0, clr_rd = 1'b0, prev_rd = 1'b0;
    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    int exp_port[$], exp_data[$], exp_rd[$];
    string exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_prog_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hold_cyc(hold_cyc),
        .dest_addr(dest_addr), .buf_idx(buf_idx), .buf_word(buf_word),
        .br_port(br_port), .br_wdata(br_wdata), .br_wr(br_wr), .br_rd(br_rd),
        .br_rdata(br_rdata), .done(done), .fail(fail));

    assign buf_word = mem[buf_idx];
    // Device model: busy for busy_n reads, then ready with the chosen error bit.
    assign br_rdata = (rd_seen < busy_n) ? 8'h00 : {1'b0, 1'b1, 5'b0, fail_bit};

    always @(negedge clk) begin
        if (clr_rd) rd_seen <= 0;
        else if (prev_rd && !br_rd) rd_seen <= rd_seen + 1;
        prev_rd <= br_rd;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input int p, input int d, input int r, input string t);
        exp_port.push_back(p); exp_data.push_back(d);
        exp_rd.push_back(r);   exp_tag.push_back(t);
    endtask

    // Expected access list built from the requirements.
    task automatic build(input bit timeout);
        exp_port.delete(); exp_data.delete(); exp_rd.delete(); exp_tag.delete();
        push(8, 0, 0, "R3"); push(3, 0, 0, "R3"); push(4, 0, 0, "R3"); push(7, 0, 0, "R3");
        push(1, 'h80, 0, "R4"); push(2, 0, 0, "R4");
        push(0, dest_addr[7:0], 0, "R5"); push(0, dest_addr[15:8], 0, "R5");
        push(0, dest_addr[23:16], 0, "R5");
        push(3, 0, 0, "R6");
        for (int i = 0; i < 32; i++) push(0, (mem[i/4] >> (8*(i%4))) & 'hFF, 0, "R6");
        push(1, 'h10, 0, "R7"); push(1, 'h70, 0, "R7");
        if (timeout) begin
            for (int i = 0; i < POLL_LIMIT; i++) push(0, 0, 1, "R10");
            push(9, 0, 0, "R10");
        end else begin
            for (int i = 0; i <= busy_n; i++) push(0, 0, 1, "R8");
            push(6, 0, 0, "R9"); push(0, 0, 1, "R9"); push(9, 0, 0, "R9");
        end
    endtask

    // Drives one operation and compares every cycle against the model.
    task automatic run_op(input int hold, input int busy, input logic fb,
                          input bit timeout, input bit noise);
        int h = (hold == 0) ? 1 : hold;
        bit excl_bad = 0;
        string dtag = timeout ? "R10" : "R9";
        hold_cyc = HOLD_W'(hold); busy_n = busy; fail_bit = fb;
        clr_rd = 1'b1;
        build(timeout);
        @(negedge clk); clr_rd = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(!br_wr && !br_rd && !done, "R11", "idle cycle after start", {br_wr, br_rd}, 0);
        for (int k = 0; k < exp_port.size(); k++) begin
            bit ok = 1;
            bit tim_ok = 1;
            for (int c = 0; c < h; c++) begin
                @(negedge clk);
                start = (noise && k == 20 && c == 0);
                if (br_wr && br_rd) excl_bad = 1;
                if (br_wr != !exp_rd[k][0] || br_rd != exp_rd[k][0]) tim_ok = 0;
                if (br_port != exp_port[k][3:0] || br_wdata != exp_data[k][7:0]) ok = 0;
            end
            start = 1'b0;
            for (int g = 1; g <= GAP_CYC; g++) begin
                @(negedge clk);
                if (br_wr || br_rd) tim_ok = 0;
                if (k == exp_port.size() - 1 && g == GAP_CYC) begin
                    check(done == 1'b1, dtag, "done pulse", done, 1);
                    check(fail == (timeout | fb), dtag, "fail flag", fail, timeout | fb);
                end else if (done) tim_ok = 0;
            end
            check(ok, exp_tag[k], $sformatf("access %0d port/data", k),
                  {br_port, br_wdata}, {exp_port[k][3:0], exp_data[k][7:0]});
            check(tim_ok, "R11", $sformatf("access %0d strobe/gap", k), {br_wr, br_rd}, exp_rd[k]);
        end
        @(negedge clk);
        check(!done, "R9", "done lasts one cycle", done, 0);
        check(!excl_bad, "R12", "read and write strobes together", excl_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = 32'h1000_0000 * i + 32'h0302_0100 + 32'h0404_0404 * i;
        repeat (3) @(negedge clk);
        check(!br_wr && !br_rd && !done && !fail, "R1", "outputs in reset",
              {br_wr, br_rd, done, fail}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!br_wr && !br_rd && !done && !fail, "R1", "outputs after reset",
              {br_wr, br_rd, done, fail}, 0);

        dest_addr = 24'hA5C3E7;
        run_op(2, 2, 1'b0, 0, 0);                 // pass, two busy polls
        dest_addr = 24'h0F1E2D;
        mem[3] = 32'hDEADBEEF;
        run_op(1, 0, 1'b1, 0, 0);                 // program error reported
        run_op(0, 20, 1'b0, 1, 0);                // timeout, hold 0 acts as 1
        dest_addr = 24'h123456;
        run_op(3, 1, 1'b0, 0, 1);                 // R2: start during operation ignored

        begin
            bit quiet = 1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (br_wr || br_rd || done) quiet = 0;
            end
            check(quiet, "R2", "no access without start", quiet, 1);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule